// File: doc/BRIEF.md
# Next-PC Sequencer with Branch and Jump Targets

This block holds the program counter of a simple in-order core and picks the address of the following instruction on every enabled clock edge. By default it steps to the next sequential word, PC+4. It also builds two redirect addresses. The first is a conditional branch target: a signed 16-bit word offset, scaled to bytes, is added to PC+4. The second is an absolute jump target: a 26-bit word index is placed in the current 256 MB region of PC+4.

Decode logic supplies three class strobes: branch-when-equal, branch-when-different and jump. It also supplies the offset and index fields and the two register values to compare. The hardware can only test for equality and inequality. Ordered comparisons are left to other instructions. The block's only output is the current PC, which fetch logic uses directly.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_q` equals `START_ADDR` (default 32'h0040_0000) at once and without waiting for a clock edge. After release, the PC changes only on rising edges of `clk`.
- R2: With `adv_en` low, a rising edge leaves `pc_q` unchanged, whatever the other inputs are.
- R3: With `adv_en` high and none of `is_beq`, `is_bne`, `is_jump` high, the next PC is PC+4, wrapping modulo 2^32.
- R4: With `is_beq` high (and `is_jump` low) and `opnd_a == opnd_b`, the next PC is PC+4 + (sign-extended `br_offset` << 2).
- R5: With `is_beq` high, `is_bne` low, `is_jump` low and `opnd_a != opnd_b`, the next PC is PC+4.
- R6: With `is_bne` high, `is_jump` low and the operands different, the next PC is the branch target of R4. If the operands are equal and `is_beq` is low, the next PC is PC+4.
- R7: `br_offset` is a two's-complement word count. 16'h8000 moves −32768 words from PC+4, 16'h7FFF moves +32767 words, and the sum wraps modulo 2^32.
- R8: With `is_jump` high, the next PC is {PC+4[31:28], `jmp_index`, 2'b00}, whatever the compare operands are.
- R9: `is_jump` takes priority over `is_beq` and `is_bne`.
- R10: If `is_beq` and `is_bne` are both high without `is_jump`, the branch is taken when either condition holds, so it is always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Clock enable for the PC register |
| is_beq | input | 1 | Branch-when-equal strobe |
| is_bne | input | 1 | Branch-when-different strobe |
| is_jump | input | 1 | Unconditional jump strobe |
| br_offset | input | 16 | Signed branch word offset |
| jmp_index | input | 26 | Jump word index |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| pc_q | output | 32 | Current program counter |

## Verification
The PC is the block's only state and it is visible directly at `pc_q`. A wrong next-address choice therefore appears one cycle after the enabled edge that caused it. The error then stays, because every later address is built on the wrong value. A bench model that tracks the PC across thousands of mixed random and directed steps catches a bad sign extension, a bad region merge, a bad priority or a bad compare on the first vector that exercises it.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  always_comb begin
    addr_o = addr_i + STEP_V;
  end
endmodule

// File: rtl/pcseq_eq.sv
module pcseq_eq #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic         same_o
);
  logic [W-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign diff[g] = lhs_i[g] ^ rhs_i[g];
    end
  endgenerate

  assign same_o = ~|diff;
endmodule

// File: rtl/pcseq_targets.sv
module pcseq_targets #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [ADDR_W-1:0] br_tgt_o,
  output logic [ADDR_W-1:0] jmp_tgt_o
);
  localparam int EXT_W    = ADDR_W - OFF_W - SHIFT;
  localparam int REGION_W = ADDR_W - IDX_W - SHIFT;

  logic [ADDR_W-1:0] byte_disp;

  always_comb begin
    byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SHIFT{1'b0}}};
    br_tgt_o  = seq_pc_i + byte_disp;
  end

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_tgt_o = {seq_pc_i[ADDR_W-1 -: REGION_W], index_i, {SHIFT{1'b0}}};
    end else begin : g_flat
      assign jmp_tgt_o = ADDR_W'({index_i, {SHIFT{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer #(
  parameter int          ADDR_W     = 32,
  parameter int          OFF_W      = 16,
  parameter int          IDX_W      = 26,
  parameter int          SHIFT      = 2,
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              is_beq,
  input  logic              is_bne,
  input  logic              is_jump,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [IDX_W-1:0]  jmp_index,
  input  logic [ADDR_W-1:0] opnd_a,
  input  logic [ADDR_W-1:0] opnd_b,
  output logic [ADDR_W-1:0] pc_q
);
  import pcseq_pkg::*;

  localparam int          STEP    = 1 << SHIFT;
  localparam logic [ADDR_W-1:0] RST_PC = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic [ADDR_W-1:0] pc_d;
  logic              ops_same;
  logic              br_taken;
  nxt_sel_e          sel;

  pcseq_incr #(.W(ADDR_W), .STEP(STEP)) u_incr (
    .addr_i (pc_q),
    .addr_o (seq_pc)
  );

  pcseq_eq #(.W(ADDR_W)) u_eq (
    .lhs_i  (opnd_a),
    .rhs_i  (opnd_b),
    .same_o (ops_same)
  );

  pcseq_targets #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .SHIFT  (SHIFT)
  ) u_tgt (
    .seq_pc_i  (seq_pc),
    .offset_i  (br_offset),
    .index_i   (jmp_index),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  // Select: jump wins, then any satisfied branch condition, else sequential
  always_comb begin
    br_taken = (is_beq & ops_same) | (is_bne & ~ops_same);
    if (is_jump)       sel = NXT_JUMP;
    else if (br_taken) sel = NXT_BRANCH;
    else               sel = NXT_SEQ;
    unique case (sel)
      NXT_JUMP:   pc_d = jmp_tgt;
      NXT_BRANCH: pc_d = br_tgt;
      default:    pc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RST_PC;
    else if (adv_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  parameter int SHIFT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_en,
  input logic              is_beq,
  input logic              is_bne,
  input logic              is_jump,
  input logic [OFF_W-1:0]  br_offset,
  input logic [IDX_W-1:0]  jmp_index,
  input logic [ADDR_W-1:0] opnd_a,
  input logic [ADDR_W-1:0] opnd_b,
  input logic [ADDR_W-1:0] pc_q
);
  localparam int EXT_W    = ADDR_W - OFF_W - SHIFT;
  localparam int REGION_W = ADDR_W - IDX_W - SHIFT;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(1 << SHIFT);

  logic [ADDR_W-1:0] c_seq;
  logic [ADDR_W-1:0] c_br;
  logic [ADDR_W-1:0] c_jmp;
  logic              c_eq;

  always_comb begin
    c_seq = pc_q + STEP_V;
    c_br  = c_seq + {{EXT_W{br_offset[OFF_W-1]}}, br_offset, {SHIFT{1'b0}}};
    c_jmp = {c_seq[ADDR_W-1 -: REGION_W], jmp_index, {SHIFT{1'b0}}};
    c_eq  = (opnd_a == opnd_b);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(pc_q));

  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !is_jump && !is_beq && !is_bne |=> pc_q == $past(c_seq));

  assert_beq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !is_jump && is_beq && c_eq |=> pc_q == $past(c_br));

  assert_beq_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !is_jump && is_beq && !is_bne && !c_eq |=> pc_q == $past(c_seq));

  assert_bne_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !is_jump && is_bne && !c_eq |=> pc_q == $past(c_br));

  assert_jump_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && is_jump |=> pc_q == $past(c_jmp));

  assert_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !is_jump && is_beq && is_bne |=> pc_q == $past(c_br));
endmodule

bind fetch_pc_sequencer pcseq_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .IDX_W  (IDX_W),
  .SHIFT  (SHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv_en    (adv_en),
  .is_beq    (is_beq),
  .is_bne    (is_bne),
  .is_jump   (is_jump),
  .br_offset (br_offset),
  .jmp_index (jmp_index),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .pc_q      (pc_q)
);

// File: tb/fetch_pc_sequencer_test.sv
module fetch_pc_sequencer_test;
  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_en, is_beq, is_bne, is_jump;
  logic [15:0] br_offset;
  logic [25:0] jmp_index;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] pc_q;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  logic [31:0] model;

  always #5 clk = ~clk;

  fetch_pc_sequencer #(.START_ADDR(START)) uut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .is_beq(is_beq),
    .is_bne(is_bne), .is_jump(is_jump), .br_offset(br_offset),
    .jmp_index(jmp_index), .opnd_a(opnd_a), .opnd_b(opnd_b), .pc_q(pc_q)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic en,
      input logic bq, input logic bn, input logic jp, input logic [15:0] off,
      input logic [25:0] idx, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] inc;
    inc = pc + 32'd4;
    if (!en) return pc;
    if (jp) return {inc[31:28], idx, 2'b00};
    if ((bq && a == b) || (bn && a != b))
      return inc + {{14{off[15]}}, off, 2'b00};
    return inc;
  endfunction

  function automatic string tag_of(input logic en, input logic bq, input logic bn,
      input logic jp, input logic [31:0] a, input logic [31:0] b);
    if (!en) return "R2";
    if (jp) return (bq || bn) ? "R9" : "R8";
    if (bq && bn) return "R10";
    if (bq) return (a == b) ? "R4" : "R5";
    if (bn) return "R6";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_chk++;
    if (pc_q !== exp) begin
      n_bad++;
      $display("FAIL %s: pc_q=%h expected=%h", tag, pc_q, exp);
    end
  endtask

  // Called right after a falling edge; result checked at the next falling edge
  task automatic step(input logic en, input logic bq, input logic bn, input logic jp,
      input logic [15:0] off, input logic [25:0] idx, input logic [31:0] a,
      input logic [31:0] b, input string tag);
    adv_en = en; is_beq = bq; is_bne = bn; is_jump = jp;
    br_offset = off; jmp_index = idx; opnd_a = a; opnd_b = b;
    model = ref_next(model, en, bq, bn, jp, off, idx, a, b);
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    rst_n = 1'b0; adv_en = 1'b1; is_beq = 1'b0; is_bne = 1'b0; is_jump = 1'b1;
    br_offset = 16'h1234; jmp_index = 26'h3FF_FFFF; opnd_a = 0; opnd_b = 0;
    model = START;
    repeat (3) @(negedge clk);
    check("R1", START);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, "R3");
    step(0, 0, 0, 1, 16'h0, 26'h123_4567, 32'h0, 32'h0, "R2");
    step(1, 1, 0, 0, 16'h0010, 26'h0, 32'h55, 32'h55, "R4");
    step(1, 1, 0, 0, 16'h0010, 26'h0, 32'h55, 32'h56, "R5");
    step(1, 0, 1, 0, 16'hFFF0, 26'h0, 32'h1, 32'h2, "R6");
    step(1, 0, 1, 0, 16'hFFF0, 26'h0, 32'h7, 32'h7, "R6");
    step(1, 1, 0, 0, 16'h7FFF, 26'h0, 32'h9, 32'h9, "R7");
    step(1, 1, 0, 0, 16'h8000, 26'h0, 32'h9, 32'h9, "R7");
    step(1, 1, 1, 1, 16'h0004, 26'h2AA_AAAA, 32'h3, 32'h3, "R9");
    step(1, 1, 1, 0, 16'h0003, 26'h0, 32'h3, 32'h4, "R10");
    step(1, 1, 1, 0, 16'h0003, 26'h0, 32'h4, 32'h4, "R10");
    // Region of PC+4 upper bits is kept; force a wrap below zero
    step(1, 0, 0, 1, 16'h0, 26'h0, 32'h1, 32'h2, "R8");
    step(1, 1, 0, 0, 16'h8000, 26'h0, 32'h0, 32'h0, "R7");
    step(1, 0, 0, 1, 16'h0, 26'h155_5555, 32'h0, 32'h0, "R8");
    for (int i = 0; i < 4000; i++) begin
      logic en, bq, bn, jp;
      logic [31:0] a, b;
      en = ($urandom % 8) != 0;
      bq = ($urandom % 3) == 0;
      bn = ($urandom % 3) == 0;
      jp = ($urandom % 6) == 0;
      a  = $urandom;
      b  = ($urandom % 2) ? a : (a ^ (32'h1 << ($urandom % 32)));
      step(en, bq, bn, jp, 16'($urandom), 26'($urandom), a, b,
           tag_of(en, bq, bn, jp, a, b));
    end
    // Asynchronous reset in mid-run
    #2 rst_n = 1'b0;
    #1 model = START;
    check("R1", START);
    @(negedge clk);
    check("R1", START);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
  initial begin : seed
    process p;
    p = process::self();
    p.srandom(32'd20240611);
  end
endmodule